// File: doc/BRIEF.md
# Run-Length Pulse Delay Line

This block delays a vector of single-bit pulse streams by a programmable number of clock cycles, all within one clock domain. It does not keep one bit of storage per cycle of delay. An encoder watches the input vector and describes every stretch of constant value as one record: the vector's level plus the number of cycles the stretch lasted. These records enter a small circular store. A replay engine starts a fixed number of cycles after the encoder and plays each record back for its recorded length. The output is therefore a bit-exact copy of the input, shifted in time. Storage grows with the number of edges inside the delay window, not with the length of the delay.

All streams share one record, with one level bit per stream. Because of this, edges that occur together on several inputs always leave together on the output. A stretch longer than the counter can hold is split into several records that carry the same level. While the record being replayed is still open in the encoder, the replay engine reads the encoder's live run directly. This lets the delay go as low as two cycles.

The encoder has two states. ENC_IDLE captures the first sample after reset and moves to ENC_TRACK. ENC_TRACK extends the open run, or closes it into a record when the input changes or the counter is full. The replay engine also has two states. DEC_WAIT counts up to the programmed delay with the output held at zero. DEC_PLAY drives the level of the current record, and moves to the next record in the cycle its length is used up. ENC_IDLE→ENC_TRACK is taken on the first clock after reset. DEC_WAIT→DEC_PLAY is taken when the wait counter equals the captured delay.

Top module: `rle_pulse_delay`

## Requirements
- R1: While reset is high, and for clock edges 0 to D-1 after reset is released (D = captured delay, edge 0 is the first rising edge with reset low), `dout` is all zeros.
- R2: For every edge k, the value of `dout` after edge k+D equals `din` as sampled at edge k, for any D from 2 to DEPTH*(2^CNT_W-1).
- R3: Edges that occur at the same edge on several streams appear on `dout` at the same edge. Bit i of `dout` always carries stream i of `din`.
- R4: A constant stretch longer than 2^CNT_W-1 cycles (255 by default) is stored as several records and is still reproduced exactly, with no glitch at the split points.
- R5: Runs as short as one cycle, including a stream that toggles on every edge, are reproduced with no gap or extra cycle between consecutive runs.
- R6: `delay_cycles` is captured only while reset is high. Changing it after reset has no effect on the delay.
- R7: `overflow` is 0 after reset and stays 0 while the records inside the delay window fit in the DEPTH-entry store. It goes to 1 when a record is closed while the store is full and no record leaves in the same cycle.
- R8: Once set, `overflow` stays at 1 until the next reset, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset; also captures `delay_cycles` |
| delay_cycles | input | DLY_W (13) | Delay in clock cycles, valid from 2 to DEPTH*(2^CNT_W-1) |
| din | input | NSTREAM (4) | Input pulse streams, one bit per stream |
| dout | output | NSTREAM (4) | Delayed copy of `din` |
| overflow | output | 1 | Sticky flag: a record was dropped because the store was full |

## Verification
The assertions assume three things. The captured delay is at least two cycles. Inputs are driven to known values on every clock. A record the replay engine is still waiting for is never dropped, so the elapsed count can never run past a stored run length. The stimulus keeps every delay between 2 and 2000. It shapes its traffic so that at most about twenty records are in flight in the data-checked scenarios. Bit-exact comparison is switched off in the one scenario that fills the store on purpose; that scenario checks only the sticky flag.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic {
        ENC_IDLE  = 1'b0,
        ENC_TRACK = 1'b1
    } enc_state_e;

    typedef enum logic {
        DEC_WAIT = 1'b0,
        DEC_PLAY = 1'b1
    } dec_state_e;

endpackage

// File: rtl/rle_run_encoder.sv
module rle_run_encoder
    import rle_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTREAM-1:0] din,
    output logic               push,
    output logic [NSTREAM-1:0] live_level,
    output logic [CNT_W-1:0]   live_len
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    enc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ENC_IDLE;
        else     state_q <= state_d;
    end

    // next state and record-close decision
    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        unique case (state_q)
            ENC_IDLE:  state_d = ENC_TRACK;
            ENC_TRACK: push = (din != live_level) || (live_len == RUN_MAX);
            default:   state_d = ENC_IDLE;
        endcase
    end

    // open-run datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            live_level <= '0;
            live_len   <= '0;
        end else if (state_q == ENC_IDLE || push) begin
            live_level <= din;
            live_len   <= CNT_W'(1);
        end else begin
            live_len   <= live_len + CNT_W'(1);
        end
    end

    // R4: a closed record never carries a zero length
    assert_push_len_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> (live_len != '0));

endmodule

// File: rtl/rle_run_fifo.sv
module rle_run_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             valid,
    output logic             overflow
);
    localparam int unsigned   AW        = $clog2(DEPTH);
    localparam logic [AW:0]   DEPTH_CNT = DEPTH[AW:0];

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             full, do_wr, do_rd;

    assign full  = (count == DEPTH_CNT);
    assign valid = (count != '0);
    assign do_rd = pop && valid;
    assign do_wr = push && (!full || do_rd);
    assign rdata = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
            if (push && !do_wr) overflow <= 1'b1;
        end
    end

    // R2: the replay engine only consumes records that exist
    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);

    // R8: the overflow flag never clears outside reset
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: rtl/rle_run_replayer.sv
module rle_run_replayer
    import rle_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int CNT_W   = 8,
    parameter int DLY_W   = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DLY_W-1:0]   delay_cycles,
    input  logic               head_valid,
    input  logic [NSTREAM-1:0] head_level,
    input  logic [CNT_W-1:0]   head_len,
    input  logic [NSTREAM-1:0] live_level,
    output logic               pop,
    output logic [NSTREAM-1:0] dout
);
    dec_state_e       state_q, state_d;
    logic [DLY_W-1:0] dly_q, wait_cnt;
    logic [CNT_W-1:0] elapsed;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= DEC_WAIT;
        else     state_q <= state_d;
    end

    // next state, pop decision and output level
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        dout    = '0;
        unique case (state_q)
            DEC_WAIT: if (wait_cnt == dly_q) state_d = DEC_PLAY;
            DEC_PLAY: begin
                dout = head_valid ? head_level : live_level;
                pop  = head_valid && (elapsed == head_len);
            end
            default:  state_d = DEC_WAIT;
        endcase
    end

    // counters and delay capture
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q    <= delay_cycles;
            wait_cnt <= '0;
            elapsed  <= '0;
        end else if (state_q == DEC_WAIT) begin
            if (wait_cnt == dly_q) elapsed  <= CNT_W'(1);
            else                   wait_cnt <= wait_cnt + DLY_W'(1);
        end else if (pop) begin
            elapsed <= CNT_W'(1);
        end else begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

    // R5: replay of a closed record never runs past its stored length
    assert_replay_within_run_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == DEC_PLAY && head_valid) |-> (elapsed <= head_len));

    // R6: the captured delay does not move outside reset
    assert_delay_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        $stable(dly_q));

endmodule

// File: rtl/rle_pulse_delay.sv
module rle_pulse_delay #(
    parameter int NSTREAM = 4,
    parameter int CNT_W   = 8,
    parameter int DEPTH   = 32,
    parameter int DLY_W   = $clog2(DEPTH) + CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DLY_W-1:0]   delay_cycles,
    input  logic [NSTREAM-1:0] din,
    output logic [NSTREAM-1:0] dout,
    output logic               overflow
);
    localparam int REC_W = NSTREAM + CNT_W;

    logic               push, pop, head_valid;
    logic [NSTREAM-1:0] live_level;
    logic [CNT_W-1:0]   live_len;
    logic [REC_W-1:0]   head_rec;

    rle_run_encoder #(.NSTREAM(NSTREAM), .CNT_W(CNT_W)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .push       (push),
        .live_level (live_level),
        .live_len   (live_len)
    );

    rle_run_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wdata    ({live_level, live_len}),
        .pop      (pop),
        .rdata    (head_rec),
        .valid    (head_valid),
        .overflow (overflow)
    );

    rle_run_replayer #(.NSTREAM(NSTREAM), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_dec (
        .clk          (clk),
        .rst          (rst),
        .delay_cycles (delay_cycles),
        .head_valid   (head_valid),
        .head_level   (head_rec[REC_W-1:CNT_W]),
        .head_len     (head_rec[CNT_W-1:0]),
        .live_level   (live_level),
        .pop          (pop),
        .dout         (dout)
    );

    // R1: output stays quiet while reset is asserted on the previous edge
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0));

endmodule

// File: tb/test_rle_pulse_delay.sv
module test_rle_pulse_delay;
    localparam int NS    = 4;
    localparam int CW    = 8;
    localparam int DEP   = 32;
    localparam int DW    = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] dly = '0;
    logic [NS-1:0] din = '0;
    logic [NS-1:0] dout;
    logic          overflow;

    rle_pulse_delay #(.NSTREAM(NS), .CNT_W(CW), .DEPTH(DEP), .DLY_W(DW)) i_rle_pulse_delay (
        .clk(clk), .rst(rst), .delay_cycles(dly), .din(din), .dout(dout), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;
    int ecount = 0;
    int cur_d = 0;
    bit cmp_en = 1;
    int err_pre, err_post, act_first, exp_first;
    logic [15:0] lfsr = 16'hACE1;
    logic [NS-1:0] hist [0:8191];

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else begin
            hist[ecount] <= din;
            ecount <= ecount + 1;
        end
    end

    task automatic check(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset(int d);
        @(negedge clk);
        rst = 1'b1; dly = DW'(d); din = '0; cur_d = d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        err_pre = 0; err_post = 0; act_first = 0; exp_first = 0;
    endtask

    // compare current output to the reference, then drive the next input
    task automatic cyc(logic [NS-1:0] v);
        int e;
        logic [NS-1:0] exp;
        @(negedge clk);
        if (cmp_en) begin
            e = ecount - 1;
            exp = (ecount >= 1 && e >= cur_d) ? hist[e - cur_d] : '0;
            if (dout !== exp) begin
                if (err_pre + err_post == 0) begin
                    act_first = int'(dout); exp_first = int'(exp);
                end
                if (ecount == 0 || e < cur_d) err_pre++;
                else err_post++;
            end
        end
        din = v;
    endtask

    task automatic report(string pre_req, string post_req);
        check(pre_req,  err_pre == 0,  act_first, exp_first);
        check(post_req, err_post == 0, act_first, exp_first);
    endtask

    task automatic t_reset_state();
        do_reset(4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 dout in reset", dout == '0, int'(dout), 0);
        check("R7 overflow in reset", overflow == 1'b0, int'(overflow), 0);
        do_reset(4);
        repeat (4) cyc(4'hF);
        repeat (20) cyc(4'hF);
        report("R1 zero before delay", "R2 steady high after delay");
    endtask

    task automatic t_irregular();
        logic [NS-1:0] v;
        do_reset(5);
        v = '0;
        for (int i = 0; i < 400; i++) begin
            step_lfsr();
            for (int s = 0; s < NS; s++)
                if (lfsr[s*3 +: 3] == 3'd0) v[s] = ~v[s];
            cyc(v);
        end
        repeat (10) cyc(v);
        report("R1 irregular", "R2 independent streams delay 5");
        check("R7 no overflow irregular", overflow == 1'b0, int'(overflow), 0);
    endtask

    task automatic t_coincident_min_delay();
        do_reset(2);
        for (int i = 0; i < 40; i++) cyc((i % 2) ? 4'hF : 4'h0);
        report("R1 min delay", "R5 toggle every cycle delay 2");
        for (int i = 0; i < 80; i++) begin
            step_lfsr();
            cyc(lfsr[3:0]);
        end
        repeat (4) cyc(4'h9);
        check("R3 coincident edges per-cycle vectors", err_post == 0, act_first, exp_first);
    endtask

    task automatic t_long_runs();
        do_reset(300);
        repeat (600) cyc(4'h5);
        repeat (600) cyc(4'hA);
        repeat (300) cyc(4'h0);
        repeat (310) cyc(4'h3);
        report("R1 long delay", "R4 runs split at counter limit");
        check("R7 no overflow long runs", overflow == 1'b0, int'(overflow), 0);
    endtask

    task automatic t_delay_frozen();
        do_reset(7);
        dly = DW'(50);
        for (int i = 0; i < 200; i++) cyc(((i / 3) % 2) ? 4'hC : 4'h3);
        repeat (10) cyc(4'h0);
        report("R1 frozen delay", "R6 delay port changed after reset ignored");
    endtask

    task automatic t_big_delay();
        do_reset(2000);
        for (int i = 0; i < 2600; i++) cyc(((i / 100) % 2) ? 4'h5 : 4'hA);
        report("R1 delay 2000", "R2 delay 2000 record store");
        check("R7 no overflow within capacity", overflow == 1'b0, int'(overflow), 0);
    endtask

    task automatic t_overflow();
        do_reset(200);
        cmp_en = 0;
        for (int i = 0; i < 20; i++) cyc((i % 2) ? 4'h1 : 4'h0);
        check("R7 no overflow below capacity", overflow == 1'b0, int'(overflow), 0);
        for (int i = 0; i < 280; i++) cyc((i % 2) ? 4'h1 : 4'h0);
        check("R7 overflow set when store full", overflow == 1'b1, int'(overflow), 1);
        repeat (500) cyc(4'h0);
        check("R8 overflow sticky", overflow == 1'b1, int'(overflow), 1);
        do_reset(10);
        @(negedge clk);
        check("R8 overflow cleared by reset", overflow == 1'b0, int'(overflow), 0);
        cmp_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_irregular();
        t_coincident_min_delay();
        t_long_runs();
        t_delay_frozen();
        t_big_delay();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule